// File: doc/BRIEF.md
# Mailbox Request Sender

This engine pushes one request message from the host into a dword-wide circular buffer that an embedded controller drains. A request is started with a pulse on `start` that carries a transport header (complete flag, host address, client address, byte length) and a command header dword. Any payload dwords are pulled from a local store over a valid/ready stream. Before writing anything, the engine reads the host control/status register and checks whether the whole message fits in the space left in the buffer. If the message does not fit, the engine runs a buffer reset handshake with the controller and checks the space once more. If the message still does not fit, the request is refused. The engine never splits a message across several transfers.

Once the last word is written, the engine does a read-modify-write of the host register to raise an interrupt toward the controller. It then polls the controller's ready bit a bounded number of times. A one-cycle `done` pulse with `err_code` reports the outcome.

The buffer word port `cb_*` follows the usual valid/ready rules. While `cb_valid` is high and `cb_ready` is low, the word and the valid stay put. While payload words are being sent, the payload stream is passed straight through, so `pl_ready` is high only when the buffer accepts the word in the same cycle.

Top module: `mbx_req_sender`

## Requirements
- R1: After reset, `busy`, `done`, `cb_valid`, `csr_we` and `pl_ready` are low, and `err_code` is 0.
- R2: An accepted request writes exactly ceil(len/4)+1 words into the buffer, where len is `hdr_len` in bytes and the command header is counted within len.
- R3: A request whose rounded length ceil(len/4) is zero finishes at once with `err_code` 1. It writes no buffer word and makes no register write.
- R4: The first word written is the transport header. Its layout is: bit 31 = complete flag, bits 30:25 = zero, bits 24:16 = byte length, bits 15:8 = host address, bits 7:0 = client address.
- R5: Words enter the buffer in this order: the transport header, then `cmd_hdr`, then the payload words in the order they arrive on the stream.
- R6: The host register layout is: bit 0 = interrupt enable, bit 1 = interrupt status, bit 2 = interrupt generate, bit 3 = ready, bit 4 = reset, bits 15:8 = read pointer, bits 23:16 = write pointer, bits 31:24 = depth. The message fits when the write pointer is at most the depth and the word count is at most depth minus write pointer. A message that fits is sent without any reset write.
- R7: A message that does not fit starts the reset handshake. The engine waits for ready. It then writes the register with reset and interrupt generate set. It waits for ready again. It then writes the register with ready and interrupt generate set and reset clear. Finally it re-reads the register and rechecks the space.
- R8: If the message still does not fit after the handshake, the engine finishes with `err_code` 2 and writes no buffer word.
- R9: After the last word, the engine writes the host register with interrupt generate set and the reset bit clear. Every register write leaves bits 31:8 and the bits it does not change equal to the value read.
- R10: After the interrupt, the engine polls `peer_ready` up to RETRY times, with at least DELAY cycles between polls. Seeing ready gives `err_code` 0. If ready is never seen, the engine finishes with `err_code` 3.
- R11: Each accepted request gives exactly one single-cycle `done` pulse. A `start` that arrives while `busy` is high is ignored.
- R12: While `cb_valid` is high and `cb_ready` is low, `cb_valid` stays high on the next cycle and `cb_data` does not change. A payload word is consumed only in a cycle where the buffer accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; header inputs are sampled with it |
| hdr_complete | input | 1 | Complete flag for the transport header |
| hdr_host_addr | input | 8 | Host address field |
| hdr_client_addr | input | 8 | Client address field |
| hdr_len | input | 9 | Message length in bytes, command header included |
| cmd_hdr | input | 32 | Command header dword |
| pl_valid | input | 1 | Payload word valid |
| pl_data | input | 32 | Payload word |
| pl_ready | output | 1 | Payload word consumed |
| cb_valid | output | 1 | Buffer word valid |
| cb_data | output | 32 | Buffer word |
| cb_ready | input | 1 | Buffer accepts the word |
| csr_rdata | input | 32 | Current host control/status register value |
| csr_we | output | 1 | Host register write strobe |
| csr_wdata | output | 32 | Host register write value |
| peer_ready | input | 1 | Controller ready bit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 empty, 2 too large, 3 controller not ready |

## Verification
The properties assume that the payload source obeys the same hold rule as the buffer port: once `pl_valid` is raised it stays high until `pl_ready`. They also assume that `csr_rdata` shows the effect of a register write by the next cycle. The bench's payload source keeps `pl_valid` high at all times. Its register model updates the register on the edge that takes the write, clears both pointers on a reset write and advances the write pointer on each accepted word. Every loaded write pointer is at most the loaded depth.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW      = 32;
  localparam int LEN_W   = 9;
  localparam int ADDR_W  = 8;
  localparam int PTR_W   = 8;
  localparam int WC_W    = LEN_W;

  localparam int CSR_IE  = 0;
  localparam int CSR_IS  = 1;
  localparam int CSR_IG  = 2;
  localparam int CSR_RDY = 3;
  localparam int CSR_RST = 4;
  localparam int CSR_RP  = 8;
  localparam int CSR_WP  = 16;
  localparam int CSR_DEP = 24;

  typedef enum logic [1:0] {
    MBX_OK        = 2'd0,
    MBX_ERR_EMPTY = 2'd1,
    MBX_ERR_BIG   = 2'd2,
    MBX_ERR_NORDY = 2'd3
  } mbx_err_e;

  typedef enum logic [1:0] {
    EDIT_RING    = 2'd0,
    EDIT_RESET   = 2'd1,
    EDIT_RELEASE = 2'd2
  } csr_edit_e;

  function automatic logic [DW-1:0] mbx_pack_hdr(
    input logic              complete,
    input logic [LEN_W-1:0]  len,
    input logic [ADDR_W-1:0] host,
    input logic [ADDR_W-1:0] client);
    logic [DW-1:0] w;
    w = '0;
    w[31]    = complete;
    w[24:16] = len;
    w[15:8]  = host;
    w[7:0]   = client;
    return w;
  endfunction
endpackage

// File: rtl/mbx_word_count.sv
module mbx_word_count
  import mbx_pkg::*;
(
  input  logic [LEN_W-1:0] len,
  output logic [WC_W-1:0]  total,
  output logic             empty
);
  logic [WC_W-1:0] body;

  always_comb begin
    body  = WC_W'(len >> 2) + WC_W'(|len[1:0]);
    empty = (body == '0);
    total = body + WC_W'(1);
  end
endmodule

// File: rtl/mbx_fit_check.sv
module mbx_fit_check
  import mbx_pkg::*;
(
  input  logic [DW-1:0]   csr,
  input  logic [WC_W-1:0] words,
  output logic            fits
);
  logic [PTR_W-1:0] depth;
  logic [PTR_W-1:0] wptr;
  logic [WC_W-1:0]  room;

  always_comb begin
    depth = csr[CSR_DEP +: PTR_W];
    wptr  = csr[CSR_WP +: PTR_W];
    room  = WC_W'(depth) - WC_W'(wptr);
    fits  = (wptr <= depth) && (words <= room);
  end
endmodule

// File: rtl/mbx_csr_edit.sv
module mbx_csr_edit
  import mbx_pkg::*;
(
  input  logic [DW-1:0] csr_in,
  input  csr_edit_e     mode,
  output logic [DW-1:0] csr_out
);
  always_comb begin
    csr_out         = csr_in;
    csr_out[CSR_IG] = 1'b1;
    unique case (mode)
      EDIT_RESET:   csr_out[CSR_RST] = 1'b1;
      EDIT_RELEASE: begin
        csr_out[CSR_RDY] = 1'b1;
        csr_out[CSR_RST] = 1'b0;
      end
      default:      csr_out[CSR_RST] = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbx_ready_poll.sv
module mbx_ready_poll #(
  parameter int RETRY = 100,
  parameter int DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic peer_ready,
  output logic idle,
  output logic fin,
  output logic ok
);
  localparam int TRY_W = $clog2(RETRY + 1);
  localparam int GAP_W = $clog2(DELAY + 1);

  typedef enum logic [1:0] {P_IDLE, P_POLL, P_GAP} poll_st_e;

  poll_st_e          st;
  logic [TRY_W-1:0]  tries;
  logic [GAP_W-1:0]  gap;

  assign idle = (st == P_IDLE);
  assign ok   = (st == P_POLL) && peer_ready;
  assign fin  = (st == P_POLL) && (peer_ready || tries == TRY_W'(RETRY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= P_IDLE;
      tries <= '0;
      gap   <= '0;
    end else begin
      unique case (st)
        P_IDLE: if (go) begin
          st    <= P_POLL;
          tries <= '0;
        end
        P_POLL: if (fin) begin
          st <= P_IDLE;
        end else begin
          st  <= P_GAP;
          gap <= GAP_W'(DELAY - 1);
        end
        P_GAP: if (gap == '0) begin
          st    <= P_POLL;
          tries <= tries + TRY_W'(1);
        end else begin
          gap <= gap - GAP_W'(1);
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_req_sender.sv
module mbx_req_sender
  import mbx_pkg::*;
#(
  parameter int RETRY = 100,
  parameter int DELAY = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hdr_complete,
  input  logic [ADDR_W-1:0] hdr_host_addr,
  input  logic [ADDR_W-1:0] hdr_client_addr,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic [DW-1:0]     cmd_hdr,
  input  logic              pl_valid,
  input  logic [DW-1:0]     pl_data,
  output logic              pl_ready,
  output logic              cb_valid,
  output logic [DW-1:0]     cb_data,
  input  logic              cb_ready,
  input  logic [DW-1:0]     csr_rdata,
  output logic              csr_we,
  output logic [DW-1:0]     csr_wdata,
  input  logic              peer_ready,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RW1, S_RSET, S_RW2, S_RREL, S_RECHK,
    S_HDR, S_CMD, S_PL, S_IRQ, S_FWAIT
  } snd_st_e;

  snd_st_e          st;
  logic [DW-1:0]    hdr_q;
  logic [DW-1:0]    cmd_q;
  logic [WC_W-1:0]  words_q;
  logic [WC_W-1:0]  pl_left_q;
  logic             done_q;
  mbx_err_e         err_q;

  logic [WC_W-1:0]  len_words;
  logic             len_empty;
  logic             fits;
  logic             p_go, p_idle, p_fin, p_ok;
  csr_edit_e        edit_mode;

  mbx_word_count u_wc (
    .len   (hdr_len),
    .total (len_words),
    .empty (len_empty)
  );

  mbx_fit_check u_fit (
    .csr   (csr_rdata),
    .words (words_q),
    .fits  (fits)
  );

  mbx_csr_edit u_edit (
    .csr_in  (csr_rdata),
    .mode    (edit_mode),
    .csr_out (csr_wdata)
  );

  assign p_go = p_idle && ((st == S_RW1) || (st == S_RW2) || (st == S_FWAIT));

  mbx_ready_poll #(.RETRY(RETRY), .DELAY(DELAY)) u_poll (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (p_go),
    .peer_ready (peer_ready),
    .idle       (p_idle),
    .fin        (p_fin),
    .ok         (p_ok)
  );

  always_comb begin
    cb_valid = 1'b0;
    cb_data  = hdr_q;
    pl_ready = 1'b0;
    unique case (st)
      S_HDR: cb_valid = 1'b1;
      S_CMD: begin
        cb_valid = 1'b1;
        cb_data  = cmd_q;
      end
      S_PL: begin
        cb_valid = pl_valid;
        cb_data  = pl_data;
        pl_ready = cb_ready;
      end
      default: ;
    endcase
  end

  always_comb begin
    csr_we    = (st == S_RSET) || (st == S_RREL) || (st == S_IRQ);
    edit_mode = EDIT_RING;
    if (st == S_RSET) edit_mode = EDIT_RESET;
    if (st == S_RREL) edit_mode = EDIT_RELEASE;
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hdr_q     <= '0;
      cmd_q     <= '0;
      words_q   <= '0;
      pl_left_q <= '0;
      done_q    <= 1'b0;
      err_q     <= MBX_OK;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (len_empty) begin
            done_q <= 1'b1;
            err_q  <= MBX_ERR_EMPTY;
          end else begin
            hdr_q     <= mbx_pack_hdr(hdr_complete, hdr_len, hdr_host_addr, hdr_client_addr);
            cmd_q     <= cmd_hdr;
            words_q   <= len_words;
            pl_left_q <= len_words - WC_W'(2);
            err_q     <= MBX_OK;
            st        <= S_CHECK;
          end
        end
        S_CHECK: st <= fits ? S_HDR : S_RW1;
        S_RW1:   if (p_fin) st <= p_ok ? S_RSET : S_RECHK;
        S_RSET:  st <= S_RW2;
        S_RW2:   if (p_fin) st <= p_ok ? S_RREL : S_RECHK;
        S_RREL:  st <= S_RECHK;
        S_RECHK: if (fits) begin
          st <= S_HDR;
        end else begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          err_q  <= MBX_ERR_BIG;
        end
        S_HDR: if (cb_ready) st <= S_CMD;
        S_CMD: if (cb_ready) st <= (pl_left_q == '0) ? S_IRQ : S_PL;
        S_PL:  if (pl_valid && cb_ready) begin
          pl_left_q <= pl_left_q - WC_W'(1);
          if (pl_left_q == WC_W'(1)) st <= S_IRQ;
        end
        S_IRQ:   st <= S_FWAIT;
        S_FWAIT: if (p_fin) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          err_q  <= p_ok ? MBX_OK : MBX_ERR_NORDY;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_req_sender_chk.sv
module mbx_req_sender_chk
  import mbx_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          cb_valid,
  input logic          cb_ready,
  input logic [DW-1:0] cb_data,
  input logic          pl_ready,
  input logic          csr_we,
  input logic [DW-1:0] csr_wdata,
  input logic [DW-1:0] csr_rdata
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cb_valid && !csr_we && !pl_ready));

  p_cb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && !cb_ready) |=> (cb_valid && $stable(cb_data)));

  p_csr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> (csr_wdata[31:8] == csr_rdata[31:8] &&
                csr_wdata[CSR_IG] &&
                csr_wdata[CSR_IE] == csr_rdata[CSR_IE] &&
                csr_wdata[CSR_IS] == csr_rdata[CSR_IS]));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_reset_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wdata[CSR_RST]) |=> !cb_valid);
endmodule

bind mbx_req_sender mbx_req_sender_chk u_chk (.*);

// File: tb/mbx_req_sender_tb.sv
`timescale 1ns/1ps
module mbx_req_sender_tb;
  import mbx_pkg::*;

  localparam int RETRY = 16;
  localparam int DELAY = 8;
  localparam logic [31:0] PL_BASE = 32'hC0DE_0000;
  localparam logic [31:0] CMD     = 32'h00FF_0C01;
  localparam int NVEC = 8;
  // {len, depth, wptr, err, words, reset_expected}
  localparam logic [35:0] VEC [NVEC] = '{
    {9'd4,  8'd16, 8'd0,  2'd0, 8'd2,  1'b0},
    {9'd5,  8'd16, 8'd0,  2'd0, 8'd3,  1'b0},
    {9'd20, 8'd16, 8'd10, 2'd0, 8'd6,  1'b0},
    {9'd0,  8'd16, 8'd0,  2'd1, 8'd0,  1'b0},
    {9'd16, 8'd8,  8'd5,  2'd0, 8'd5,  1'b1},
    {9'd40, 8'd8,  8'd0,  2'd2, 8'd0,  1'b1},
    {9'd12, 8'd8,  8'd4,  2'd0, 8'd4,  1'b0},
    {9'd13, 8'd8,  8'd4,  2'd0, 8'd5,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] hdr_len = '0;
  logic pl_ready, cb_valid, cb_ready, csr_we, busy, done;
  logic [31:0] cb_data, csr_wdata, pl_data;
  logic [1:0] err_code;
  logic peer_ready = 1'b1;
  logic [31:0] csr = '0;

  logic ld = 1'b0, bp = 1'b0, toggle = 1'b0;
  logic [7:0] ld_depth = '0, ld_wr = '0;
  logic [31:0] cap [16];
  logic [31:0] wlog [8];
  int ncap = 0, nw = 0, pl_idx = 0, done_cnt = 0;
  logic rst_seen = 1'b0;
  int nchk = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk;

  assign pl_data  = PL_BASE + 32'(pl_idx);
  assign cb_ready = bp ? toggle : 1'b1;

  mbx_req_sender #(.RETRY(RETRY), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr_complete(1'b1),
    .hdr_host_addr(8'h21), .hdr_client_addr(8'h07), .hdr_len(hdr_len),
    .cmd_hdr(CMD), .pl_valid(1'b1), .pl_data(pl_data), .pl_ready(pl_ready),
    .cb_valid(cb_valid), .cb_data(cb_data), .cb_ready(cb_ready),
    .csr_rdata(csr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .peer_ready(peer_ready), .busy(busy), .done(done), .err_code(err_code)
  );

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    toggle <= ~toggle;
    if (ld) begin
      csr      <= {ld_depth, ld_wr, 8'h00, 8'h08};
      ncap     <= 0;
      nw       <= 0;
      pl_idx   <= 0;
      done_cnt <= 0;
      rst_seen <= 1'b0;
    end else begin
      if (cb_valid && cb_ready) begin
        if (ncap < 16) cap[ncap] <= cb_data;
        ncap <= ncap + 1;
        csr[23:16] <= csr[23:16] + 8'd1;
      end
      if (csr_we) begin
        wlog[nw % 8] <= csr_wdata;
        nw <= nw + 1;
        if (csr_wdata[CSR_RST]) begin
          rst_seen <= 1'b1;
          csr <= {csr_wdata[31:24], 16'h0000, csr_wdata[7:0]};
        end else begin
          csr <= csr_wdata;
        end
      end
      if (pl_valid_acc()) pl_idx <= pl_idx + 1;
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  function automatic logic pl_valid_acc();
    return pl_ready;
  endfunction

  task automatic chk(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  task automatic load(input logic [7:0] d, input logic [7:0] w);
    @(negedge clk);
    ld_depth = d; ld_wr = w; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic send(input logic [8:0] len, output int cycles);
    hdr_len = len;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    cycles  = 1;
    while (done_cnt == 0 && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic check_order(input int n, input logic [8:0] len, input string tag);
    logic good;
    good = 1'b1;
    if (n > 0) begin
      chk(cap[0] == {1'b1, 6'd0, len, 8'h21, 8'h07}, "R4 header", cap[0], {1'b1, 6'd0, len, 8'h21, 8'h07});
      chk(cap[1] == CMD, "R5 command second", cap[1], CMD);
      for (int k = 2; k < n; k++) if (cap[k] != PL_BASE + 32'(k - 2)) good = 1'b0;
      chk(good, tag, 32'(good), 32'd1);
    end
  endtask

  initial begin
    int cycles;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done low", {30'd0, busy, done}, 0);
    chk(!cb_valid && !csr_we && !pl_ready, "R1 ports quiet", {29'd0, cb_valid, csr_we, pl_ready}, 0);
    chk(err_code == 2'd0, "R1 err code", 32'(err_code), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] len; logic [7:0] dep, wp, nwd; logic [1:0] er; logic rs;
      {len, dep, wp, er, nwd, rs} = VEC[v];
      load(dep, wp);
      send(len, cycles);
      chk(done_cnt == 1, "R11 one done", 32'(done_cnt), 1);
      chk(err_code == er, (er == 2'd1) ? "R3 empty code" : (er == 2'd2) ? "R8 too big code" : "R10 ok code",
          32'(err_code), 32'(er));
      chk(ncap == int'(nwd), (er == 2'd0) ? "R2 word count" : "R8 no words", 32'(ncap), 32'(nwd));
      chk(rst_seen == rs, rs ? "R7 reset run" : "R6 no reset on fit", 32'(rst_seen), 32'(rs));
      if (er == 2'd1) chk(nw == 0, "R3 no register write", 32'(nw), 0);
      if (rs) begin
        chk(wlog[0][CSR_RST] && wlog[0][CSR_IG], "R7 first write reset+ig", wlog[0], 32'h14);
        chk(wlog[1][CSR_RDY] && wlog[1][CSR_IG] && !wlog[1][CSR_RST], "R7 second write release", wlog[1], 32'h0c);
      end
      if (er == 2'd0) begin
        chk(wlog[(nw - 1) % 8][CSR_IG] && !wlog[(nw - 1) % 8][CSR_RST], "R9 interrupt raised", wlog[(nw - 1) % 8], 32'h4);
        chk(wlog[(nw - 1) % 8][31:24] == dep, "R9 depth kept", 32'(wlog[(nw - 1) % 8][31:24]), 32'(dep));
        check_order(ncap, len, "R5 payload order");
      end
    end

    // R10 controller never ready
    load(8'd16, 8'd0);
    peer_ready = 1'b0;
    send(9'd8, cycles);
    chk(err_code == 2'd3, "R10 timeout code", 32'(err_code), 3);
    chk(cycles >= (RETRY - 1) * DELAY, "R10 poll window", 32'(cycles), 32'((RETRY - 1) * DELAY));
    chk(ncap == 3, "R2 words before timeout", 32'(ncap), 3);
    peer_ready = 1'b1;

    // R11 start while busy is ignored
    load(8'd16, 8'd0);
    hdr_len = 9'd8;
    start = 1'b1;
    @(negedge clk);
    hdr_len = 9'd40;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (80) @(negedge clk);
    chk(done_cnt == 1, "R11 single done", 32'(done_cnt), 1);
    chk(ncap == 3, "R11 busy start ignored", 32'(ncap), 3);

    // R12 back-pressure on the buffer port
    load(8'd16, 8'd0);
    bp = 1'b1;
    send(9'd16, cycles);
    bp = 1'b0;
    chk(err_code == 2'd0, "R12 ok under back-pressure", 32'(err_code), 0);
    chk(ncap == 5, "R12 word count", 32'(ncap), 5);
    chk(pl_idx == 3, "R12 payload consumed", 32'(pl_idx), 3);
    check_order(ncap, 9'd16, "R12 payload order");

    finish_run();
  end

  initial begin
    wait (cyc > 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    finish_run();
  end
endmodule